// File: doc/BRIEF.md
# Per-CPU Dual-Mode Counter/Timer Bank

This block holds one counter/timer for each of `NCPU` processors plus a system-level mode register. In system mode, each counter counts tick pulses up to a programmed limit. When it reaches the limit it sets a reached flag, raises that processor's interrupt and starts again from zero. A limit of zero makes the counter free-run over its full range. When software sets a processor's bit in the mode register, that counter becomes a wide free-running user counter. The user counter never interrupts. It is read as an upper and a lower 32-bit word, and it can be started and stopped.

Access is by word index on a simple register port. `sel_sys` selects the system instance, which holds only the mode register at index 4. Otherwise `sel_cpu` selects a processor timer. Its indices are: 0 = limit (or upper count word), 1 = count with reached flag (or lower count word), 2 = limit load without counter reset, 3 = run control. A read returns its data on `rdata` one cycle after `rd_en`. The count advances only on cycles where `tick` is high. The count field starts at bit `LSB` of the 64-bit view, and the bits below it always read as zero.

Top module: `cpu_timer_bank`

## Requirements
- R1: After reset every mode bit is 0, every interrupt is low, every run flag reads 1 at index 3, and every limit (index 0) reads bits 30..LSB set and all other bits clear.
- R2: In system mode, writing index 0 stores the limit (bits 30..LSB of the write data) and clears the count. After P ticks, where P is the limit shifted right by LSB, the count returns to zero and the reached flag and the interrupt are set. Index 0 reads back the stored limit.
- R3: In system mode, a zero limit makes the counter run a full period of 2^(31-LSB)-1 ticks before it sets reached.
- R4: In system mode, a read of index 1 returns the reached flag at bit 31 and the count at bits 30..LSB. A read of index 0 clears both the reached flag and the interrupt.
- R5: Writing index 2 changes the limit but leaves the count unchanged. A write of index 1 in system mode has no effect.
- R6: A write of index 4 on the system instance stores the data bits below NCPU into the mode register. Each processor whose bit is written as 1 has its interrupt lowered and its limit set to all ones.
- R7: A processor whose mode bit changes value has its count cleared and its run flag set.
- R8: A processor in user mode never raises its interrupt, whatever its count does.
- R9: In user mode, index 0 reads bits 63..32 of the count view. Index 1 reads bits 31..0, and the value latched by the last index-0 read is returned first if there is one, so a carry between the words is read consistently.
- R10: In user mode, writing index 0 or index 1 clears the count and lowers the interrupt.
- R11: In user mode, writing index 3 with bit 0 = 0 stops the count and writing 1 restarts it. Index 3 bit 0 reads the run flag.
- R12: A write of index 4 to a processor timer leaves the mode register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per count period |
| sel_sys | input | 1 | 1 selects the system instance (mode register) |
| sel_cpu | input | SW | Processor timer select when sel_sys is 0 |
| idx | input | 3 | Register word index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data appears on rdata the next cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | NCPU | Per-processor interrupt |

## Verification
The bench builds the bank with NCPU = 4 and LSB = 24. With these values, a limit period is at most 127 ticks, so both the period-match and the zero-limit free-run wraps are reached within a short run. The lower count word holds only 8 count bits, so the carry from the lower word into the upper word happens after 256 ticks. This brings the latched two-word read within reach of the bench.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    // Word indices decoded by the processor timers and the system instance
    localparam logic [2:0] IX_LIM   = 3'd0;
    localparam logic [2:0] IX_CNT   = 3'd1;
    localparam logic [2:0] IX_NORST = 3'd2;
    localparam logic [2:0] IX_RUN   = 3'd3;
    localparam logic [2:0] IX_MODE  = 3'd4;
endpackage

// File: rtl/ctb_mode.sv
module ctb_mode #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NCPU-1:0] wbits,
    output logic [NCPU-1:0] mode,
    output logic [NCPU-1:0] set_one,
    output logic [NCPU-1:0] flip
);
    logic [NCPU-1:0] mode_d, mode_q;

    always_comb begin
        mode_d  = mode_q;
        set_one = '0;
        flip    = '0;
        if (wr) begin
            mode_d  = wbits;
            set_one = wbits;
            flip    = wbits ^ mode_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/ctb_unit.sv
module ctb_unit
    import ctb_pkg::*;
#(
    parameter int LSB = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        user,
    input  logic        mode_set,
    input  logic        mode_flip,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [2:0]  idx,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    localparam int CW = 63 - LSB;   // count bits in the 64-bit view
    localparam int PW = 31 - LSB;   // period bits in the limit field
    localparam logic [30:0] LIM_MASK = {{PW{1'b1}}, {LSB{1'b0}}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [30:0]   lim;
        logic          reached;
        logic          irq;
        logic          run;
        logic [31:0]   snap;
        logic          snap_vld;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic [63:0]   view;
    logic [PW-1:0] per;
    logic [CW-1:0] cnt_inc;
    logic          wrap;
    logic          adv;
    logic          cnt_rst;
    logic          unused_top;

    assign unused_top = wdata[31];
    assign view       = {1'b0, st_q.cnt, {LSB{1'b0}}};
    assign cnt_inc    = st_q.cnt + 1'b1;

    always_comb begin
        per = st_q.lim[30:LSB];
        if (per == '0) per = '1;
    end

    assign wrap = ({{(CW-PW){1'b0}}, per} <= cnt_inc);
    assign adv  = tick && (!user || st_q.run);

    // Read data for the selected word, from the current state
    always_comb begin
        unique case (idx)
            IX_LIM:  rdata = user ? view[63:32] : {1'b0, st_q.lim};
            IX_CNT:  rdata = user ? (st_q.snap_vld ? st_q.snap : view[31:0])
                                  : {st_q.reached, view[30:0]};
            IX_RUN:  rdata = {31'd0, st_q.run};
            default: rdata = '0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        cnt_rst = 1'b0;

        if (rd_en) begin
            if (idx == IX_LIM) begin
                if (user) begin
                    st_d.snap     = view[31:0];
                    st_d.snap_vld = 1'b1;
                end else begin
                    st_d.reached = 1'b0;
                    st_d.irq     = 1'b0;
                end
            end else if (idx == IX_CNT && user) begin
                st_d.snap_vld = 1'b0;
            end
        end

        if (wr_en) begin
            if (idx == IX_LIM || idx == IX_CNT) begin
                if (user) begin
                    st_d.irq = 1'b0;
                    st_d.lim = '1;
                    cnt_rst  = 1'b1;
                end else if (idx == IX_LIM) begin
                    st_d.irq = 1'b0;
                    st_d.lim = wdata[30:0] & LIM_MASK;
                    cnt_rst  = 1'b1;
                end
            end else if (idx == IX_NORST) begin
                st_d.lim = wdata[30:0] & LIM_MASK;
            end else if (idx == IX_RUN && user) begin
                st_d.run = wdata[0];
            end
        end

        if (mode_set) begin
            st_d.irq = 1'b0;
            st_d.lim = '1;
        end
        if (mode_flip) begin
            cnt_rst  = 1'b1;
            st_d.run = 1'b1;
        end

        if (cnt_rst) begin
            st_d.cnt      = '0;
            st_d.snap_vld = 1'b0;
        end else if (adv) begin
            if (user) begin
                st_d.cnt = cnt_inc;
            end else if (wrap) begin
                st_d.cnt     = '0;
                st_d.reached = 1'b1;
                st_d.irq     = 1'b1;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt      <= '0;
            st_q.lim      <= LIM_MASK;
            st_q.reached  <= 1'b0;
            st_q.irq      <= 1'b0;
            st_q.run      <= 1'b1;
            st_q.snap     <= '0;
            st_q.snap_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/cpu_timer_bank.sv
module cpu_timer_bank
    import ctb_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int LSB  = 9,
    localparam int SW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            sel_sys,
    input  logic [SW-1:0]   sel_cpu,
    input  logic [2:0]      idx,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    output logic [NCPU-1:0] irq
);
    localparam int NSLOT = 2 ** SW;

    logic [NCPU-1:0] mode_q;
    logic [NCPU-1:0] mode_set;
    logic [NCPU-1:0] mode_flip;
    logic            mode_wr;
    logic [31:0]     unit_rd [NSLOT];
    logic [31:0]     rdata_d, rdata_q;

    assign mode_wr = wr_en && sel_sys && (idx == IX_MODE);

    ctb_mode #(.NCPU(NCPU)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mode_wr),
        .wbits   (wdata[NCPU-1:0]),
        .mode    (mode_q),
        .set_one (mode_set),
        .flip    (mode_flip)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < NCPU) begin : g_unit
            logic hit;
            assign hit = !sel_sys && (sel_cpu == SW'(i));
            ctb_unit #(.LSB(LSB)) u_unit (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .user      (mode_q[i]),
                .mode_set  (mode_set[i]),
                .mode_flip (mode_flip[i]),
                .rd_en     (rd_en && hit),
                .wr_en     (wr_en && hit),
                .idx       (idx),
                .wdata     (wdata),
                .rdata     (unit_rd[i]),
                .irq       (irq[i])
            );
        end else begin : g_empty
            assign unit_rd[i] = '0;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            if (sel_sys) rdata_d = (idx == IX_MODE) ? 32'(mode_q) : '0;
            else         rdata_d = unit_rd[sel_cpu];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/ctb_checks.sv
module ctb_checks #(
    parameter int NCPU = 4,
    parameter int SW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            sel_sys,
    input logic [SW-1:0]   sel_cpu,
    input logic [2:0]      idx,
    input logic            wr_en,
    input logic            rd_en,
    input logic [NCPU-1:0] wlow,
    input logic [NCPU-1:0] irq,
    input logic [NCPU-1:0] mode
);
    a_r6_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_sys && idx == 3'd4) |=> (mode == $past(wlow)));

    a_r12_cpu_write_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_sys) |=> $stable(mode));

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        a_r8_user_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
            mode[i] |-> !irq[i]);

        a_r2_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(tick));

        a_r4_limit_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !sel_sys && sel_cpu == SW'(i) && idx == 3'd0 && !mode[i] && !tick)
            |=> !irq[i]);
    end
endmodule

bind cpu_timer_bank ctb_checks #(.NCPU(NCPU), .SW(SW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sel_sys (sel_sys),
    .sel_cpu (sel_cpu),
    .idx     (idx),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wlow    (wdata[NCPU-1:0]),
    .irq     (irq),
    .mode    (mode_q)
);

// File: tb/cpu_timer_bank_bench.sv
module cpu_timer_bank_bench;
    localparam int CLK_NS = 10;
    localparam int N      = 4;
    localparam int LSB    = 24;
    localparam int SW     = 2;
    localparam longint unsigned LIMM = ((64'h1 << 31) - 1) & ~((64'h1 << LSB) - 1);
    localparam longint unsigned PMAX = (64'h1 << (31 - LSB)) - 1;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sel_sys = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [SW-1:0] sel_cpu = '0;
    logic [2:0]    idx = '0;
    logic [31:0]   wdata = '0;
    wire  [31:0]   rdata;
    wire  [N-1:0]  irq;

    always #(CLK_NS/2) clk = ~clk;

    cpu_timer_bank #(.NCPU(N), .LSB(LSB)) u_cpu_timer_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_sys(sel_sys), .sel_cpu(sel_cpu),
        .idx(idx), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Behavioural reference state
    bit              m_mode [N];
    longint unsigned m_lim  [N];
    longint unsigned m_cnt  [N];
    longint unsigned m_snap [N];
    bit              m_reach[N];
    bit              m_irq  [N];
    bit              m_run  [N];
    bit              m_sv   [N];
    logic [31:0]     m_rd;

    int    n_chk = 0, n_err = 0;
    string req = "R1";
    bit    finished = 0;

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic logic [31:0] read_value();
        longint unsigned v;
        int c;
        logic [31:0] mv;
        if (sel_sys) begin
            mv = '0;
            for (int k = 0; k < N; k++) mv[k] = m_mode[k];
            return (idx == 3'd4) ? mv : 32'd0;
        end
        c = int'(sel_cpu);
        v = m_cnt[c] << LSB;
        case (idx)
            3'd0: return m_mode[c] ? v[63:32] : m_lim[c][31:0];
            3'd1: if (m_mode[c]) return m_sv[c] ? m_snap[c][31:0] : v[31:0];
                  else return {m_reach[c], v[30:0]};
            3'd3: return {31'd0, m_run[c]};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                m_mode[k] = 0; m_lim[k] = LIMM; m_cnt[k] = 0; m_snap[k] = 0;
                m_reach[k] = 0; m_irq[k] = 0; m_run[k] = 1; m_sv[k] = 0;
            end
            m_rd = '0;
        end else begin
            if (rd_en) m_rd = read_value();
            for (int k = 0; k < N; k++) begin
                bit me, u, r0, clr;
                longint unsigned per;
                me  = !sel_sys && (int'(sel_cpu) == k);
                u   = m_mode[k];
                r0  = m_run[k];
                clr = 0;
                per = m_lim[k] >> LSB;
                if (per == 0) per = PMAX;
                if (me && rd_en && idx == 3'd0) begin
                    if (u) begin m_snap[k] = (m_cnt[k] << LSB) & 64'hffff_ffff; m_sv[k] = 1; end
                    else begin m_reach[k] = 0; m_irq[k] = 0; end
                end
                if (me && rd_en && idx == 3'd1 && u) m_sv[k] = 0;
                if (me && wr_en) begin
                    if (u && idx <= 3'd1) begin m_irq[k] = 0; m_lim[k] = 64'h7fff_ffff; clr = 1; end
                    else if (!u && idx == 3'd0) begin m_irq[k] = 0; m_lim[k] = wdata & LIMM; clr = 1; end
                    else if (idx == 3'd2) m_lim[k] = wdata & LIMM;
                    else if (idx == 3'd3 && u) m_run[k] = wdata[0];
                end
                if (sel_sys && wr_en && idx == 3'd4) begin
                    if (wdata[k]) begin m_irq[k] = 0; m_lim[k] = 64'h7fff_ffff; end
                    if (wdata[k] != u) begin clr = 1; m_run[k] = 1; end
                end
                if (clr) begin
                    m_cnt[k] = 0; m_sv[k] = 0;
                end else if (tick && (!u || r0)) begin
                    if (u) m_cnt[k]++;
                    else if (m_cnt[k] + 1 >= per) begin m_cnt[k] = 0; m_reach[k] = 1; m_irq[k] = 1; end
                    else m_cnt[k]++;
                end
            end
            if (sel_sys && wr_en && idx == 3'd4)
                for (int k = 0; k < N; k++) m_mode[k] = wdata[k];
        end
    end

    // Compare with the reference on every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            logic [31:0] mi;
            mi = '0;
            for (int k = 0; k < N; k++) mi[k] = m_irq[k];
            chk(req, "irq vs model", 32'(irq), mi);
            chk(req, "rdata vs model", rdata, m_rd);
        end
    end

    task automatic wr(input bit sys, input int cpu, input int ix, input logic [31:0] d);
        @(negedge clk);
        sel_sys = sys; sel_cpu = SW'(cpu); idx = 3'(ix); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit sys, input int cpu, input int ix, output logic [31:0] v);
        @(negedge clk);
        sel_sys = sys; sel_cpu = SW'(cpu); idx = 3'(ix); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic run(input int n, input bit gapped);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            tick = gapped ? c[0] : 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_up();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        req = "R1";
        rd(0, 0, 0, v); chk("R1", "reset limit", v, 32'h7f00_0000);
        rd(0, 3, 3, v); chk("R1", "reset run flag", v, 32'd1);
        rd(1, 0, 4, v); chk("R1", "reset mode", v, 32'd0);
        chk("R1", "reset irq", 32'(irq), 32'd0);

        req = "R2";
        wr(0, 1, 0, 32'h0500_0000);
        run(12, 0);
        chk("R2", "irq after period", 32'(irq[1]), 32'd1);
        req = "R4";
        rd(0, 1, 1, v); chk("R4", "reached bit", 32'(v[31]), 32'd1);
        rd(0, 1, 0, v); chk("R2", "limit readback", v, 32'h0500_0000);
        chk("R4", "irq cleared by limit read", 32'(irq[1]), 32'd0);

        req = "R5";
        wr(0, 1, 1, 32'h1234_5678);
        wr(0, 1, 2, 32'h0900_0000);
        run(3, 0);
        rd(0, 1, 1, v); chk("R5", "count kept over limit load", v, 32'h0500_0000);

        req = "R3";
        wr(0, 2, 0, 32'd0);
        run(126, 0);
        chk("R3", "no irq before full period", 32'(irq[2]), 32'd0);
        run(1, 0);
        chk("R3", "irq at full period", 32'(irq[2]), 32'd1);

        req = "R6";
        wr(1, 0, 4, 32'h0000_00f3);
        rd(1, 0, 4, v); chk("R6", "mode masked", v, 32'd3);
        chk("R6", "irq lowered on mode set", 32'(irq[1:0]), 32'd0);
        req = "R7";
        rd(0, 1, 3, v); chk("R7", "running after flip", v, 32'd1);

        req = "R8";
        run(300, 0);
        chk("R8", "no user irq", 32'(irq[1:0]), 32'd0);
        req = "R9";
        rd(0, 0, 0, v); chk("R9", "upper word carry", v, 32'd1);
        rd(0, 0, 1, v); chk("R9", "lower word", v, 32'h2c00_0000);
        rd(0, 1, 0, v); chk("R9", "upper word cpu1", v, 32'd1);
        run(20, 0);
        rd(0, 1, 1, v); chk("R9", "latched lower word", v, 32'h2c00_0000);
        rd(0, 1, 1, v); chk("R9", "live lower word", v, 32'h4000_0000);

        req = "R11";
        wr(0, 1, 3, 32'd0);
        run(10, 0);
        rd(0, 1, 1, v); chk("R11", "stopped count", v, 32'h4000_0000);
        rd(0, 1, 3, v); chk("R11", "run flag low", v, 32'd0);
        wr(0, 1, 3, 32'd1);
        run(5, 0);
        rd(0, 1, 1, v); chk("R11", "restarted count", v, 32'h4500_0000);

        req = "R10";
        wr(0, 0, 1, 32'hdead_beef);
        rd(0, 0, 0, v); chk("R10", "upper word after reset", v, 32'd0);
        rd(0, 0, 1, v); chk("R10", "lower word after reset", v, 32'd0);

        req = "R12";
        wr(0, 2, 4, 32'd0);
        rd(1, 0, 4, v); chk("R12", "mode unchanged", v, 32'd3);

        req = "R7";
        wr(1, 0, 4, 32'd1);
        rd(0, 1, 0, v); chk("R6", "limit all ones", v, 32'h7fff_ffff);
        run(126, 0);
        chk("R7", "no irq before period after flip", 32'(irq[1]), 32'd0);
        run(1, 0);
        chk("R7", "irq after restart from zero", 32'(irq[1]), 32'd1);

        req = "R2";
        run(200, 1);
        rd(0, 3, 1, v);
        chk("R8", "cpu0 still quiet", 32'(irq[0]), 32'd0);

        finish_up();
    end
endmodule